// File: doc/BRIEF.md
# Partitioned Quadlet Buffer Manager

The block owns one 512-word by 32-bit store (2 KB) and divides it at run time into three circular queues: asynchronous receive, asynchronous transmit and isochronous. Each queue keeps its own write pointer, read pointer and fill count. Each queue accepts a push and a pop request in every cycle. The head word of each queue is always present on its pop data lane. A pop takes that word away at the next clock edge.

A size register holds two 9-bit fields, counted in 32-bit words. The receive split `RX` sets the receive queue to words 0 to RX-1. The total split `TOT` sets the transmit queue to words RX to TOT-1. The isochronous queue takes words TOT to 511. A write that breaks the size rules is ignored and sets a sticky error flag. A valid resize empties the queues that the change touches.

A control register starts soft resets that clear themselves. Software can start a transmit reset, a link reset or a transfer-engine reset. Each one runs a short two-state machine: `RST_IDLE` goes to `RST_HOLD` when a control write sets any reset bit. `RST_HOLD` goes back to `RST_IDLE` after a fixed hold time. A transfer-engine reset rewinds the transmit read pointer to the start of the packet it is in, so the engine can read that packet again.

Top module: `qbuf_partition_mgr`

## Requirements
- R1: After reset the size register reads 0x007F00FF (RX=127 in bits 24..16, TOT=255 in bits 8..0), the control and status registers read 0, and every queue is empty with count 0.
- R2: Queue capacities are RX for receive (queue 0), TOT-RX for transmit (queue 1) and 512-TOT for isochronous (queue 2). A queue raises full when its count reaches its capacity.
- R3: Each queue returns words in push order, including across the wrap from its last word back to its first. The head word is shown on the queue's pop data lane, and a pop removes it at the next edge.
- R4: A push to a full queue is dropped, and its count is unchanged. The queue's overflow output is high for the one cycle after any rejected push. A pop on an empty queue is ignored.
- R5: A size write (address 1) is accepted only if 5 <= RX < TOT. Otherwise the register keeps its value and status bit 0 (address 2) becomes 1. That bit stays 1 until a status write with bit 0 set.
- R6: An accepted size write that changes TOT empties all three queues at that write edge.
- R7: An accepted size write that changes RX but not TOT empties the receive and transmit queues only. An accepted write that changes neither field empties nothing.
- R8: In the control register (address 0), bit 4 is the transmit reset, bit 5 the link reset and bit 6 the transfer-engine reset. A control write that sets any of them while no reset is running makes the written bits read 1 for exactly 4 cycles after the write edge, then 0. A control write while a reset is running is ignored.
- R9: A transmit reset empties only the transmit queue. A link reset empties all three queues. Both take effect at the write edge.
- R10: During the write cycle and the 4 hold cycles, pushes and pops to the queues a reset affects are rejected, and each rejected push raises overflow. The transmit and transfer-engine resets affect the transmit queue. The link reset affects all three queues.
- R11: A transfer-engine reset moves the transmit read pointer back to the word after the last pop made with `tx_pop_eop` high (or the queue start if there has been none). The transmit count grows by the number of words popped since then.
- R12: `cfg_rdata` shows the register at `cfg_addr` in the same cycle. Address 3 reads 0.
- R13: A push and a pop on the same queue in one cycle both take effect, leaving the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 size, 2 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data at cfg_addr |
| size_err | output | 1 | Sticky flag for a rejected size write |
| q_push | input | 3 | Push request per queue (0 rx, 1 tx, 2 iso) |
| q_push_data | input | 96 | Push words, queue i in bits 32*i+31..32*i |
| q_pop | input | 3 | Pop request per queue |
| tx_pop_eop | input | 1 | Marks a transmit pop as the last word of a packet |
| q_pop_data | output | 96 | Head word of each queue |
| q_count | output | 30 | Fill count per queue, 10 bits each |
| q_full | output | 3 | Queue at capacity |
| q_empty | output | 3 | Queue holds no words |
| q_ovf | output | 3 | A push was rejected in the previous cycle |

## Verification
The assertions check these on every cycle:
- A push to a full queue is always followed by an overflow pulse, and overflow never appears without a push.
- A count never exceeds its region's capacity.
- A rejected size write leaves both fields as they were and sets the error flag.
- Each reset hold lasts exactly four cycles.
- Pushes to the transmit queue during a hold are refused.

Only the bench scenarios can show the rest:
- Data order across the wrap.
- Which queues a given resize or reset empties, and that the others keep their contents.
- The packet rewind of a transfer-engine reset.

// File: rtl/qbuf_pkg.sv
package qbuf_pkg;
    localparam int QW          = 32;
    localparam int DEPTH       = 512;
    localparam int AW          = $clog2(DEPTH);
    localparam int CW          = AW + 1;
    localparam int NQ          = 3;
    localparam int Q_RX        = 0;
    localparam int Q_TX        = 1;
    localparam int Q_ISO       = 2;
    localparam int HOLD_CYCLES = 4;
    localparam int MIN_RX      = 5;

    localparam logic [AW-1:0] RX_RST  = 9'h07F;
    localparam logic [AW-1:0] TOT_RST = 9'h0FF;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SIZE = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // control bit positions, decoded by software
    localparam int BIT_TXRST   = 4;
    localparam int BIT_LINKRST = 5;
    localparam int BIT_DMARST  = 6;

    // reset mask index order: 0 transmit, 1 link, 2 transfer engine
    localparam int M_TX   = 0;
    localparam int M_LINK = 1;
    localparam int M_DMA  = 2;

    typedef enum logic [0:0] {
        RST_IDLE = 1'b0,
        RST_HOLD = 1'b1
    } rst_state_e;
endpackage

// File: rtl/qbuf_region_ctl.sv
module qbuf_region_ctl
    import qbuf_pkg::*;
#(
    parameter int RAW = AW,
    parameter int RCW = CW,
    parameter logic [RAW-1:0] RST_BASE = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] base,
    input  logic [RCW-1:0] size,
    input  logic [RAW-1:0] flush_base,
    input  logic           flush,
    input  logic           block,
    input  logic           push,
    input  logic           pop,
    input  logic           pop_eop,
    input  logic           rewind,
    output logic           wr_en,
    output logic [RAW-1:0] wr_addr,
    output logic [RAW-1:0] rd_addr,
    output logic [RCW-1:0] count,
    output logic           full,
    output logic           empty,
    output logic           ovf
);
    logic [RAW-1:0] wp, rp, hp;
    logic [RCW-1:0] cnt, since;
    logic [RCW-1:0] last_addr;
    logic           push_ok, pop_ok;
    logic [RAW-1:0] wp_nx, rp_nx;

    assign last_addr = RCW'(base) + size - RCW'(1);
    assign wp_nx     = ({1'b0, wp} == last_addr) ? base : wp + RAW'(1);
    assign rp_nx     = ({1'b0, rp} == last_addr) ? base : rp + RAW'(1);

    assign full    = (cnt == size);
    assign empty   = (cnt == '0);
    assign push_ok = push && !block && !flush && !full;
    assign pop_ok  = pop  && !block && !flush && !empty;

    assign wr_en   = push_ok;
    assign wr_addr = wp;
    assign rd_addr = rp;
    assign count   = cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= RST_BASE;
            rp    <= RST_BASE;
            hp    <= RST_BASE;
            cnt   <= '0;
            since <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= push && !push_ok;
            if (flush) begin
                wp    <= flush_base;
                rp    <= flush_base;
                hp    <= flush_base;
                cnt   <= '0;
                since <= '0;
            end else if (rewind) begin
                rp    <= hp;
                cnt   <= cnt + since;
                since <= '0;
            end else begin
                if (push_ok) wp <= wp_nx;
                if (pop_ok) begin
                    rp <= rp_nx;
                    if (pop_eop) begin
                        hp    <= rp_nx;
                        since <= '0;
                    end else begin
                        since <= since + RCW'(1);
                    end
                end
                unique case ({push_ok, pop_ok})
                    2'b10:   cnt <= cnt + RCW'(1);
                    2'b01:   cnt <= cnt - RCW'(1);
                    default: cnt <= cnt;
                endcase
            end
        end
    end
endmodule

// File: rtl/qbuf_cfg_regs.sv
module qbuf_cfg_regs
    import qbuf_pkg::*;
#(
    parameter int RAW = AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [31:0]    cfg_wdata,
    input  logic [2:0]     busy_mask,
    output logic [31:0]    cfg_rdata,
    output logic [RAW-1:0] rx_q,
    output logic [RAW-1:0] tot_q,
    output logic [RAW-1:0] rx_d,
    output logic [RAW-1:0] tot_d,
    output logic           size_err,
    output logic           flush_all,
    output logic           flush_async
);
    logic [RAW-1:0] new_rx, new_tot;
    logic           wr_size, size_ok, accept, wr_stat;
    logic           unused_wbits;

    assign new_tot = cfg_wdata[RAW-1:0];
    assign new_rx  = cfg_wdata[16 +: RAW];
    assign unused_wbits = ^{cfg_wdata[31:16+RAW], cfg_wdata[15:RAW]};

    assign wr_size = cfg_we && (cfg_addr == ADDR_SIZE);
    assign wr_stat = cfg_we && (cfg_addr == ADDR_STAT);
    assign size_ok = (new_rx >= RAW'(MIN_RX)) && (new_rx < new_tot);
    assign accept  = wr_size && size_ok;

    assign flush_all   = accept && (new_tot != tot_q);
    assign flush_async = accept && (new_rx != rx_q);

    assign rx_d  = accept ? new_rx  : rx_q;
    assign tot_d = accept ? new_tot : tot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q     <= RX_RST;
            tot_q    <= TOT_RST;
            size_err <= 1'b0;
        end else begin
            rx_q  <= rx_d;
            tot_q <= tot_d;
            if (wr_size && !size_ok)
                size_err <= 1'b1;
            else if (wr_stat && cfg_wdata[0])
                size_err <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            ADDR_CTRL: begin
                cfg_rdata[BIT_TXRST]   = busy_mask[M_TX];
                cfg_rdata[BIT_LINKRST] = busy_mask[M_LINK];
                cfg_rdata[BIT_DMARST]  = busy_mask[M_DMA];
            end
            ADDR_SIZE: begin
                cfg_rdata[RAW-1:0]   = tot_q;
                cfg_rdata[16 +: RAW] = rx_q;
            end
            ADDR_STAT: cfg_rdata[0] = size_err;
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qbuf_softrst_fsm.sv
module qbuf_softrst_fsm
    import qbuf_pkg::*;
#(
    parameter int HOLD = HOLD_CYCLES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [2:0]    req_bits,
    output logic [2:0]    busy_mask,
    output logic [NQ-1:0] flush_mask,
    output logic [NQ-1:0] block_mask,
    output logic          rewind_tx
);
    localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;

    rst_state_e     state, state_d;
    logic [HW-1:0]  hold_cnt;
    logic [2:0]     act_mask;
    logic           start;
    logic [2:0]     launch;

    function automatic logic [NQ-1:0] affected(input logic [2:0] m);
        logic [NQ-1:0] a;
        a        = '0;
        a[Q_TX]  = m[M_TX] | m[M_DMA] | m[M_LINK];
        a[Q_RX]  = m[M_LINK];
        a[Q_ISO] = m[M_LINK];
        return a;
    endfunction

    assign start  = ctl_wr && (|req_bits) && (state == RST_IDLE);
    assign launch = start ? req_bits : 3'b000;

    always_comb begin
        state_d = state;
        unique case (state)
            RST_IDLE: if (start) state_d = RST_HOLD;
            RST_HOLD: if (hold_cnt == HW'(HOLD - 1)) state_d = RST_IDLE;
            default:  state_d = RST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RST_IDLE;
            hold_cnt <= '0;
            act_mask <= '0;
        end else begin
            state <= state_d;
            if (start) begin
                act_mask <= req_bits;
                hold_cnt <= '0;
            end else if (state == RST_HOLD) begin
                hold_cnt <= hold_cnt + HW'(1);
            end
        end
    end

    always_comb begin
        busy_mask  = (state == RST_HOLD) ? act_mask : 3'b000;
        flush_mask = '0;
        flush_mask[Q_TX]  = launch[M_TX] | launch[M_LINK];
        flush_mask[Q_RX]  = launch[M_LINK];
        flush_mask[Q_ISO] = launch[M_LINK];
        rewind_tx  = launch[M_DMA] && !launch[M_TX] && !launch[M_LINK];
        block_mask = affected(launch | busy_mask);
    end
endmodule

// File: rtl/qbuf_partition_mgr.sv
module qbuf_partition_mgr
    import qbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             size_err,
    input  logic [NQ-1:0]    q_push,
    input  logic [NQ*QW-1:0] q_push_data,
    input  logic [NQ-1:0]    q_pop,
    input  logic             tx_pop_eop,
    output logic [NQ*QW-1:0] q_pop_data,
    output logic [NQ*CW-1:0] q_count,
    output logic [NQ-1:0]    q_full,
    output logic [NQ-1:0]    q_empty,
    output logic [NQ-1:0]    q_ovf
);
    logic [AW-1:0] rx_size_q, tot_size_q, rx_size_d, tot_size_d;
    logic          flush_all, flush_async;
    logic [2:0]    busy_mask;
    logic [NQ-1:0] rst_flush, blk, flush_q;
    logic          rewind_tx;

    logic [AW-1:0] q_base  [NQ];
    logic [AW-1:0] q_fbase [NQ];
    logic [CW-1:0] q_size  [NQ];
    logic [AW-1:0] wr_addr [NQ];
    logic [AW-1:0] rd_addr [NQ];
    logic [NQ-1:0] wr_en;

    logic [QW-1:0] mem [DEPTH];

    qbuf_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .busy_mask   (busy_mask),
        .cfg_rdata   (cfg_rdata),
        .rx_q        (rx_size_q),
        .tot_q       (tot_size_q),
        .rx_d        (rx_size_d),
        .tot_d       (tot_size_d),
        .size_err    (size_err),
        .flush_all   (flush_all),
        .flush_async (flush_async)
    );

    qbuf_softrst_fsm u_rst (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (cfg_we && (cfg_addr == ADDR_CTRL)),
        .req_bits   ({cfg_wdata[BIT_DMARST], cfg_wdata[BIT_LINKRST], cfg_wdata[BIT_TXRST]}),
        .busy_mask  (busy_mask),
        .flush_mask (rst_flush),
        .block_mask (blk),
        .rewind_tx  (rewind_tx)
    );

    always_comb begin
        q_base[Q_RX]   = '0;
        q_base[Q_TX]   = rx_size_q;
        q_base[Q_ISO]  = tot_size_q;
        q_fbase[Q_RX]  = '0;
        q_fbase[Q_TX]  = rx_size_d;
        q_fbase[Q_ISO] = tot_size_d;
        q_size[Q_RX]   = {1'b0, rx_size_q};
        q_size[Q_TX]   = {1'b0, tot_size_q} - {1'b0, rx_size_q};
        q_size[Q_ISO]  = CW'(DEPTH) - {1'b0, tot_size_q};
    end

    assign flush_q[Q_RX]  = flush_all | flush_async | rst_flush[Q_RX];
    assign flush_q[Q_TX]  = flush_all | flush_async | rst_flush[Q_TX];
    assign flush_q[Q_ISO] = flush_all | rst_flush[Q_ISO];

    for (genvar gq = 0; gq < NQ; gq++) begin : g_q
        localparam logic [AW-1:0] RB = (gq == Q_RX) ? '0 :
                                       (gq == Q_TX) ? RX_RST : TOT_RST;
        qbuf_region_ctl #(.RST_BASE(RB)) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .base       (q_base[gq]),
            .size       (q_size[gq]),
            .flush_base (q_fbase[gq]),
            .flush      (flush_q[gq]),
            .block      (blk[gq]),
            .push       (q_push[gq]),
            .pop        (q_pop[gq]),
            .pop_eop    ((gq == Q_TX) ? tx_pop_eop : 1'b0),
            .rewind     ((gq == Q_TX) ? rewind_tx : 1'b0),
            .wr_en      (wr_en[gq]),
            .wr_addr    (wr_addr[gq]),
            .rd_addr    (rd_addr[gq]),
            .count      (q_count[gq*CW +: CW]),
            .full       (q_full[gq]),
            .empty      (q_empty[gq]),
            .ovf        (q_ovf[gq])
        );
        assign q_pop_data[gq*QW +: QW] = mem[rd_addr[gq]];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NQ; i++) begin
            if (wr_en[i]) mem[wr_addr[i]] <= q_push_data[i*QW +: QW];
        end
    end
endmodule

// File: rtl/qbuf_pm_checker.sv
module qbuf_pm_checker
    import qbuf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_addr,
    input logic [31:0]      cfg_wdata,
    input logic             size_err,
    input logic [AW-1:0]    rx_size,
    input logic [AW-1:0]    tot_size,
    input logic [2:0]       busy_mask,
    input logic [NQ-1:0]    q_push,
    input logic [NQ-1:0]    q_full,
    input logic [NQ-1:0]    q_ovf,
    input logic [NQ*CW-1:0] q_count
);
    logic [3:0]    run;
    logic [CW-1:0] cap [NQ];
    logic          bad_wr;

    assign cap[Q_RX]  = {1'b0, rx_size};
    assign cap[Q_TX]  = {1'b0, tot_size} - {1'b0, rx_size};
    assign cap[Q_ISO] = CW'(DEPTH) - {1'b0, tot_size};

    assign bad_wr = cfg_we && (cfg_addr == ADDR_SIZE) &&
                    !((cfg_wdata[16 +: AW] >= AW'(MIN_RX)) &&
                      (cfg_wdata[16 +: AW] < cfg_wdata[AW-1:0]));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           run <= '0;
        else if (|busy_mask)  run <= run + 4'd1;
        else                  run <= '0;
    end

    for (genvar gq = 0; gq < NQ; gq++) begin : g_a
        // R4
        push_full_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_push[gq] && q_full[gq]) |=> q_ovf[gq]);
        // R4
        no_spurious_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !q_push[gq] |=> !q_ovf[gq]);
        // R2
        cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            q_count[gq*CW +: CW] <= cap[gq]);
    end

    // R5
    bad_size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> (size_err && $stable(rx_size) && $stable(tot_size)));

    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|busy_mask) |-> (run == 4'(HOLD_CYCLES)));

    // R10
    tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|busy_mask) && q_push[Q_TX]) |=> q_ovf[Q_TX]);
endmodule

bind qbuf_partition_mgr qbuf_pm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .size_err  (size_err),
    .rx_size   (rx_size_q),
    .tot_size  (tot_size_q),
    .busy_mask (busy_mask),
    .q_push    (q_push),
    .q_full    (q_full),
    .q_ovf     (q_ovf),
    .q_count   (q_count)
);

// File: tb/qbuf_partition_mgr_tb.sv
`timescale 1ns/1ps
module qbuf_partition_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        size_err;
    logic [2:0]  q_push = '0;
    logic [95:0] q_push_data = '0;
    logic [2:0]  q_pop = '0;
    logic        tx_pop_eop = 1'b0;
    logic [95:0] q_pop_data;
    logic [29:0] q_count;
    logic [2:0]  q_full, q_empty, q_ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [31:0] mq [3][$];
    int m_rx = 127;
    int m_tot = 255;

    always #2.5 clk = ~clk;

    qbuf_partition_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .size_err(size_err),
        .q_push(q_push), .q_push_data(q_push_data), .q_pop(q_pop),
        .tx_pop_eop(tx_pop_eop), .q_pop_data(q_pop_data), .q_count(q_count),
        .q_full(q_full), .q_empty(q_empty), .q_ovf(q_ovf)
    );

    function automatic int rsize(int i);
        if (i == 0) return m_rx;
        if (i == 1) return m_tot - m_rx;
        return 512 - m_tot;
    endfunction

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [1:0] a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_check(string rq, logic [1:0] a, logic [31:0] exp);
        cfg_addr = a;
        #1;
        chk(rq, "rdata", cfg_rdata, exp);
    endtask

    task automatic do_cycle(logic [2:0] ps, logic [2:0] pp, logic eop,
                            logic [95:0] d, string rq);
        bit ap [3];
        bit ao [3];
        q_push = ps; q_pop = pp; tx_pop_eop = eop; q_push_data = d;
        #1;
        for (int i = 0; i < 3; i++) begin
            if (mq[i].size() > 0) chk(rq, "head", q_pop_data[i*32 +: 32], mq[i][0]);
            ap[i] = ps[i] && (mq[i].size() < rsize(i));
            ao[i] = pp[i] && (mq[i].size() > 0);
        end
        tick();
        for (int i = 0; i < 3; i++) begin
            if (ao[i]) void'(mq[i].pop_front());
            if (ap[i]) mq[i].push_back(d[i*32 +: 32]);
            chk(rq, "ovf", q_ovf[i], ps[i] && !ap[i]);
            chk(rq, "count", q_count[i*10 +: 10], mq[i].size());
        end
        q_push = '0; q_pop = '0; tx_pop_eop = 1'b0;
    endtask

    task automatic rand_burst(int n, string rq);
        for (int k = 0; k < n; k++) begin
            do_cycle(3'($urandom), 3'($urandom), 1'($urandom),
                     {$urandom, $urandom, $urandom}, rq);
        end
    endtask

    function automatic logic [31:0] size_word(int rx, int tot);
        return (32'(rx) << 16) | 32'(tot);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c_rx;
        int c_iso;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R12 reset state
        cfg_check("R1", 2'd1, 32'h007F00FF);
        cfg_check("R1", 2'd0, 32'h0);
        cfg_check("R1", 2'd2, 32'h0);
        cfg_check("R12", 2'd3, 32'h0);
        chk("R1", "counts", q_count, 30'h0);
        chk("R1", "empty", q_empty, 3'b111);

        // R2 R4 fill receive queue to capacity, then overflow
        for (int k = 0; k < 127; k++) do_cycle(3'b001, 3'b000, 1'b0, {64'h0, 32'(k + 32'hA000)}, "R2");
        chk("R2", "rx full", q_full[0], 1'b1);
        do_cycle(3'b001, 3'b000, 1'b0, {64'h0, 32'hDEAD}, "R4");
        for (int k = 0; k < 127; k++) do_cycle(3'b000, 3'b001, 1'b0, '0, "R3");
        do_cycle(3'b000, 3'b001, 1'b0, '0, "R4");
        // R13 push and pop together on a non-empty queue
        do_cycle(3'b111, 3'b000, 1'b0, {32'h1, 32'h2, 32'h3}, "R13");
        do_cycle(3'b111, 3'b111, 1'b0, {32'h4, 32'h5, 32'h6}, "R13");

        // R3 random traffic with wrap
        rand_burst(3000, "R3");

        // R5 rejected size writes
        cfg_write(2'd1, size_word(4, 255));
        cfg_check("R5", 2'd1, 32'h007F00FF);
        cfg_check("R5", 2'd2, 32'h1);
        cfg_write(2'd2, 32'h1);
        cfg_check("R5", 2'd2, 32'h0);
        cfg_write(2'd1, size_word(300, 255));
        cfg_check("R5", 2'd2, 32'h1);
        cfg_write(2'd1, size_word(200, 200));
        cfg_check("R5", 2'd1, 32'h007F00FF);
        cfg_write(2'd2, 32'h1);

        // R7 same-value write keeps everything, rx change flushes async only
        do_cycle(3'b111, 3'b000, 1'b0, {32'h11, 32'h22, 32'h33}, "R7");
        c_iso = mq[2].size();
        c_rx = mq[0].size();
        cfg_write(2'd1, size_word(127, 255));
        chk("R7", "rx kept", q_count[9:0], c_rx);
        cfg_write(2'd1, size_word(64, 255));
        m_rx = 64;
        mq[0].delete(); mq[1].delete();
        chk("R7", "rx flushed", q_count[9:0], 0);
        chk("R7", "tx flushed", q_count[19:10], 0);
        chk("R7", "iso kept", q_count[29:20], c_iso);
        do_cycle(3'b000, 3'b100, 1'b0, '0, "R7");

        // R6 total change flushes all
        do_cycle(3'b111, 3'b000, 1'b0, {32'h44, 32'h55, 32'h66}, "R6");
        cfg_write(2'd1, size_word(64, 300));
        m_tot = 300;
        mq[0].delete(); mq[1].delete(); mq[2].delete();
        chk("R6", "counts", q_count, 30'h0);
        cfg_check("R6", 2'd1, 32'h0040012C);
        rand_burst(500, "R2");

        // R8 R9 R10 transmit reset
        do_cycle(3'b011, 3'b000, 1'b0, {32'h0, 32'h77, 32'h88}, "R9");
        c_rx = mq[0].size();
        c_iso = mq[2].size();
        cfg_write(2'd0, 32'h10);
        mq[1].delete();
        cfg_check("R8", 2'd0, 32'h10);
        chk("R9", "tx flushed", q_count[19:10], 0);
        chk("R9", "rx kept", q_count[9:0], c_rx);
        chk("R9", "iso kept", q_count[29:20], c_iso);
        for (int k = 0; k < 4; k++) begin
            q_push = 3'b010; q_push_data = {32'h0, 32'hBAD, 32'h0};
            tick();
            q_push = '0;
            chk("R10", "tx push blocked ovf", q_ovf[1], 1'b1);
            chk("R10", "tx count", q_count[19:10], 0);
            cfg_check("R8", 2'd0, (k < 3) ? 32'h10 : 32'h0);
        end
        do_cycle(3'b010, 3'b000, 1'b0, {32'h0, 32'h99, 32'h0}, "R10");

        // R9 link reset flushes all
        do_cycle(3'b111, 3'b000, 1'b0, {32'h1, 32'h2, 32'h3}, "R9");
        cfg_write(2'd0, 32'h20);
        mq[0].delete(); mq[1].delete(); mq[2].delete();
        cfg_check("R8", 2'd0, 32'h20);
        chk("R9", "all flushed", q_count, 30'h0);
        q_push = 3'b001; q_push_data = 96'h5;
        tick();
        q_push = '0;
        chk("R10", "rx push blocked by link", q_ovf[0], 1'b1);
        repeat (3) tick();
        cfg_check("R8", 2'd0, 32'h0);

        // R11 transfer-engine rewind
        for (int k = 0; k < 6; k++) do_cycle(3'b010, 3'b000, 1'b0, {32'h0, 32'(32'hC0 + k), 32'h0}, "R11");
        do_cycle(3'b000, 3'b010, 1'b0, '0, "R11");
        do_cycle(3'b000, 3'b010, 1'b1, '0, "R11");
        do_cycle(3'b000, 3'b010, 1'b0, '0, "R11");
        cfg_write(2'd0, 32'h40);
        mq[1].push_front(32'hC2);
        cfg_check("R8", 2'd0, 32'h40);
        chk("R11", "tx count", q_count[19:10], 4);
        chk("R11", "tx head", q_pop_data[63:32], 32'hC2);
        repeat (4) tick();
        for (int k = 0; k < 4; k++) do_cycle(3'b000, 3'b010, 1'b0, '0, "R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule